// File: doc/BRIEF.md
# 8-bit Accumulator Core

A compact sequential processor that executes a three-opcode subset of a classic 8-bit instruction set. Instruction bytes come from an external program memory through a synchronous read port. The core drives an address and a read strobe, and the memory returns the addressed byte on the following cycle. The architectural state is an 8-bit accumulator, an 8-bit index register, an 8-bit status register and a program counter. All of these are exposed on ports so that a surrounding test or debug environment can observe them.

After reset the core sits halted and makes no reads. A one-cycle start pulse moves the program counter to address zero and starts the fetch loop. The loop runs until the core meets a stop opcode or an opcode it does not recognise. It then halts again and keeps its registers, so a later start can run another program. Load-immediate takes three cycles: the opcode request, the operand request, and the cycle in which the operand is written. Transfer and stop take two cycles each.

Top module: `cpu8_core`

## Requirements
- R1: During and after reset, before any start, acc, xreg and status are 0x00, halted is 1, illegal is 0 and mem_rd is 0.
- R2: A cycle with start high sets pc to 0 at the next clock edge and clears halted and illegal. In the cycle after that edge, mem_rd is 1 and mem_addr is 0.
- R3: Every read presents mem_addr equal to pc with mem_rd high, and pc rises by exactly one at the following edge. The returned mem_data byte is used in the cycle after the request.
- R4: Opcode 0xA9 requests the next byte in the cycle its opcode arrives. The core writes that byte into acc one cycle later and then fetches the byte after it. The instruction takes 3 cycles.
- R5: Opcode 0xAA copies acc into xreg at the edge that ends the opcode-arrival cycle and leaves acc unchanged. The instruction takes 2 cycles.
- R6: The zero flag is status bit 1. When 0xA9 or 0xAA executes, it becomes 1 if the written value (acc for 0xA9, xreg for 0xAA) is 0x00, and 0 otherwise.
- R7: The negative flag is status bit 7. When 0xA9 or 0xAA executes, it takes bit 7 of the written value.
- R8: Status bits 0 and 2 to 6 never change. Status does not change in any cycle in which no 0xA9 or 0xAA is written.
- R9: Opcode 0x00 sets halted. The core then makes no reads, and pc, acc, xreg and status hold, with pc one past the stop opcode, until the next start.
- R10: Any opcode other than 0xA9, 0xAA or 0x00 sets illegal and halted together. Illegal stays at 1 until a start pulse.
- R11: A start pulse during a run abandons the current instruction. No pending register write takes effect, and the next fetch is from address 0. Acc, xreg and status keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse: restart execution at address 0 |
| mem_rd | output | 1 | Read strobe to program memory |
| mem_addr | output | ADDR_W | Read address (equals pc) |
| mem_data | input | 8 | Byte returned one cycle after a read |
| halted | output | 1 | Core is stopped and fetches nothing |
| illegal | output | 1 | Sticky: an unsupported opcode was met |
| acc | output | 8 | Accumulator |
| xreg | output | 8 | Index register |
| status | output | 8 | Status register (bit 7 negative, bit 1 zero) |
| pc | output | ADDR_W | Program counter |

## Verification
A sequencer that slips a cycle or loses count shows up at once on mem_rd and mem_addr. The bench compares both on every cycle, so an extra or missing read or a wrong pc is caught in the cycle it happens. A decode error changes acc, xreg, status or halted at the edge that ends the opcode-arrival cycle, and the per-cycle comparison against the behavioural model reports it within one clock. Illegal-opcode and restart paths get targeted programs, so the stickiness of illegal and the discarding of pending writes are both observed at the ports.

// File: rtl/cpu8_pkg.sv
`timescale 1ns/1ps
package cpu8_pkg;

    localparam int WORD_W  = 8;
    localparam int FLAG_Z  = 1;
    localparam int FLAG_N  = WORD_W - 1;

    localparam logic [WORD_W-1:0] OPC_LOAD_IMM = 8'hA9;
    localparam logic [WORD_W-1:0] OPC_MOVE_AX  = 8'hAA;
    localparam logic [WORD_W-1:0] OPC_STOP     = 8'h00;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_OPCODE,
        ST_OPERAND
    } seq_state_t;

    typedef enum logic [1:0] {
        OPK_LOAD,
        OPK_MOVE,
        OPK_STOP,
        OPK_BAD
    } op_kind_t;

    typedef struct packed {
        logic load_acc;
        logic load_x;
    } wr_ctl_t;

    function automatic logic [WORD_W-1:0] fold_flags(
        input logic [WORD_W-1:0] st,
        input logic [WORD_W-1:0] value
    );
        logic [WORD_W-1:0] r;
        r         = st;
        r[FLAG_Z] = (value == '0);
        r[FLAG_N] = value[WORD_W-1];
        return r;
    endfunction

endpackage

// File: rtl/cpu8_decode.sv
`timescale 1ns/1ps
module cpu8_decode
    import cpu8_pkg::*;
(
    input  logic [WORD_W-1:0] opcode,
    output op_kind_t          kind
);

    always_comb begin
        unique case (opcode)
            OPC_LOAD_IMM: kind = OPK_LOAD;
            OPC_MOVE_AX:  kind = OPK_MOVE;
            OPC_STOP:     kind = OPK_STOP;
            default:      kind = OPK_BAD;
        endcase
    end

endmodule

// File: rtl/cpu8_seq.sv
`timescale 1ns/1ps
module cpu8_seq
    import cpu8_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_kind_t          kind,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] pc,
    output wr_ctl_t           wr,
    output logic              halted,
    output logic              illegal
);

    localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

    seq_state_t state;

    always_comb begin
        mem_rd = 1'b0;
        if (!start) begin
            mem_rd = (state == ST_FETCH) ||
                     (state == ST_OPCODE && kind == OPK_LOAD);
        end
    end

    always_comb begin
        wr.load_acc = !start && (state == ST_OPERAND);
        wr.load_x   = !start && (state == ST_OPCODE) && (kind == OPK_MOVE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pc      <= '0;
            halted  <= 1'b1;
            illegal <= 1'b0;
        end else if (start) begin
            state   <= ST_FETCH;
            pc      <= '0;
            halted  <= 1'b0;
            illegal <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state <= ST_IDLE;
                end
                ST_FETCH: begin
                    pc    <= pc + PC_ONE;
                    state <= ST_OPCODE;
                end
                ST_OPCODE: begin
                    unique case (kind)
                        OPK_LOAD: begin
                            pc    <= pc + PC_ONE;
                            state <= ST_OPERAND;
                        end
                        OPK_MOVE: state <= ST_FETCH;
                        OPK_STOP: begin
                            halted <= 1'b1;
                            state  <= ST_IDLE;
                        end
                        default: begin
                            halted  <= 1'b1;
                            illegal <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    endcase
                end
                ST_OPERAND: state <= ST_FETCH;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // R3: each read advances pc by one
    a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> pc == $past(pc) + PC_ONE);

    // R9: a halted core makes no reads
    a_r9_no_read_halted: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_rd);

    // R10: illegal implies halted, and stays until start
    a_r10_illegal_halts: assert property (@(posedge clk) disable iff (rst)
        illegal |-> halted);
    a_r10_illegal_sticky: assert property (@(posedge clk) disable iff (rst)
        (illegal && !start) |=> illegal);

    // R2: start rewinds pc and clears the stop indications
    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        start |=> (pc == '0 && !halted && !illegal));

endmodule

// File: rtl/cpu8_regs.sv
`timescale 1ns/1ps
module cpu8_regs
    import cpu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_ctl_t           wr,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] acc,
    output logic [WORD_W-1:0] xreg,
    output logic [WORD_W-1:0] status
);

    localparam logic [WORD_W-1:0] FIXED_MASK =
        ~((WORD_W'(1) << FLAG_Z) | (WORD_W'(1) << FLAG_N));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            xreg   <= '0;
            status <= '0;
        end else if (wr.load_acc) begin
            acc    <= din;
            status <= fold_flags(status, din);
        end else if (wr.load_x) begin
            xreg   <= acc;
            status <= fold_flags(status, acc);
        end
    end

    // R5: transfer copies acc into xreg
    a_r5_move: assert property (@(posedge clk) disable iff (rst)
        wr.load_x |=> (xreg == $past(acc) && acc == $past(acc)));

    // R6: zero flag follows the written register
    a_r6_zero_acc: assert property (@(posedge clk) disable iff (rst)
        wr.load_acc |=> status[FLAG_Z] == (acc == '0));
    a_r6_zero_x: assert property (@(posedge clk) disable iff (rst)
        wr.load_x |=> status[FLAG_Z] == (xreg == '0));

    // R7: negative flag follows bit 7 of the written register
    a_r7_neg_acc: assert property (@(posedge clk) disable iff (rst)
        wr.load_acc |=> status[FLAG_N] == acc[WORD_W-1]);
    a_r7_neg_x: assert property (@(posedge clk) disable iff (rst)
        wr.load_x |=> status[FLAG_N] == xreg[WORD_W-1]);

    // R8: untouched bits never move; no write, no status change
    a_r8_fixed_bits: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(status & FIXED_MASK));
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr.load_acc || wr.load_x) |=> $stable(status));

endmodule

// File: rtl/cpu8_core.sv
`timescale 1ns/1ps
module cpu8_core
    import cpu8_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_data,
    output logic              halted,
    output logic              illegal,
    output logic [7:0]        acc,
    output logic [7:0]        xreg,
    output logic [7:0]        status,
    output logic [ADDR_W-1:0] pc
);

    op_kind_t kind;
    wr_ctl_t  wr;

    cpu8_decode u_decode (
        .opcode (mem_data),
        .kind   (kind)
    );

    cpu8_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .kind    (kind),
        .mem_rd  (mem_rd),
        .pc      (pc),
        .wr      (wr),
        .halted  (halted),
        .illegal (illegal)
    );

    cpu8_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .din    (mem_data),
        .acc    (acc),
        .xreg   (xreg),
        .status (status)
    );

    assign mem_addr = pc;

    // R1: idle core after reset issues no reads
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (halted && !illegal && acc == '0 && xreg == '0 && status == '0));

endmodule

// File: tb/cpu8_core_test.sv
`timescale 1ns/1ps
module cpu8_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data = 8'h00;
    logic        halted, illegal;
    logic [7:0]  acc, xreg, status;
    logic [15:0] pc;

    always #2.5 clk = ~clk;

    cpu8_core uut (
        .clk(clk), .rst(rst), .start(start),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
        .halted(halted), .illegal(illegal),
        .acc(acc), .xreg(xreg), .status(status), .pc(pc)
    );

    logic [7:0] prog [0:255];

    always @(posedge clk) if (mem_rd) mem_data <= prog[mem_addr[7:0]];

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 request opcode, 2 opcode back, 3 operand back
    int         m_ph;
    logic [7:0] m_a, m_x, m_st;
    logic [15:0] m_pc;
    logic       m_halt, m_ill;

    function automatic logic [7:0] nf(input logic [7:0] st, input logic [7:0] v);
        return (st & 8'h7D) | ((v == 8'h00) ? 8'h02 : 8'h00) | (v & 8'h80);
    endfunction

    function automatic logic [7:0] prev_byte(input logic [15:0] p);
        logic [15:0] q;
        q = p - 16'd1;
        return prog[q[7:0]];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ph <= 0; m_a <= 0; m_x <= 0; m_st <= 0;
            m_pc <= 0; m_halt <= 1'b1; m_ill <= 1'b0;
        end else if (start) begin
            m_ph <= 1; m_pc <= 0; m_halt <= 1'b0; m_ill <= 1'b0;
        end else begin
            case (m_ph)
                1: begin m_pc <= m_pc + 16'd1; m_ph <= 2; end
                2: begin
                    case (prev_byte(m_pc))
                        8'hA9: begin m_pc <= m_pc + 16'd1; m_ph <= 3; end
                        8'hAA: begin m_x <= m_a; m_st <= nf(m_st, m_a); m_ph <= 1; end
                        8'h00: begin m_halt <= 1'b1; m_ph <= 0; end
                        default: begin m_halt <= 1'b1; m_ill <= 1'b1; m_ph <= 0; end
                    endcase
                end
                3: begin
                    m_a <= prev_byte(m_pc);
                    m_st <= nf(m_st, prev_byte(m_pc));
                    m_ph <= 1;
                end
                default: m_ph <= 0;
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            logic exp_rd;
            exp_rd = !start && (m_ph == 1 || (m_ph == 2 && prev_byte(m_pc) == 8'hA9));
            chk("R3 mem_rd", mem_rd, exp_rd);
            if (exp_rd) chk("R3 mem_addr", mem_addr, m_pc);
            chk("R3 pc", pc, m_pc);
            chk("R4 acc", acc, m_a);
            chk("R5 xreg", xreg, m_x);
            chk("R6 zero flag", status[1], m_st[1]);
            chk("R7 negative flag", status[7], m_st[7]);
            chk("R8 other status bits", status & 8'h7D, m_st & 8'h7D);
            chk("R9 halted", halted, m_halt);
            chk("R10 illegal", illegal, m_ill);
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            nerr++;
            $display("FAIL R9 watchdog act=%0d exp=<20000 cycles", cyc);
            finish_run();
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_halt();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (halted) break;
        end
    endtask

    task automatic load_prog(input logic [7:0] b [], input int n);
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
        for (int i = 0; i < n; i++) prog[i] = b[i];
    endtask

    task automatic run_and_check_r2();
        pulse_start();
        @(negedge clk);
        chk("R2 first read strobe", mem_rd, 1'b1);
        chk("R2 first read address", mem_addr, 16'h0000);
        chk("R2 halted cleared", halted, 1'b0);
        chk("R2 illegal cleared", illegal, 1'b0);
        wait_halt();
    endtask

    initial begin
        logic [7:0] p [];
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 acc", acc, 8'h00);
        chk("R1 xreg", xreg, 8'h00);
        chk("R1 status", status, 8'h00);
        chk("R1 halted", halted, 1'b1);
        chk("R1 illegal", illegal, 1'b0);
        chk("R1 mem_rd", mem_rd, 1'b0);
        @(posedge clk); #1 rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 idle after reset", {halted, mem_rd}, 2'b10);

        // basic load, transfer, stop
        p = '{8'hA9, 8'h05, 8'hAA, 8'h00};
        load_prog(p, 4);
        run_and_check_r2();
        chk("R4 acc=05", acc, 8'h05);
        chk("R5 xreg=05", xreg, 8'h05);
        chk("R6 R7 status", status, 8'h00);
        chk("R9 pc past stop", pc, 16'd4);

        // zero result
        p = '{8'hA9, 8'h00, 8'hAA, 8'h00};
        load_prog(p, 4);
        run_and_check_r2();
        chk("R6 zero set", status, 8'h02);
        chk("R5 xreg=00", xreg, 8'h00);

        // negative load, X untouched
        p = '{8'hA9, 8'h80, 8'h00};
        load_prog(p, 3);
        run_and_check_r2();
        chk("R7 negative set", status, 8'h80);
        chk("R4 acc=80", acc, 8'h80);
        chk("R5 xreg kept", xreg, 8'h00);

        // transfer then reload zero
        p = '{8'hA9, 8'hF0, 8'hAA, 8'hA9, 8'h00, 8'h00};
        load_prog(p, 6);
        run_and_check_r2();
        chk("R5 xreg=F0", xreg, 8'hF0);
        chk("R6 zero after reload", status, 8'h02);
        chk("R9 pc=6", pc, 16'd6);

        // illegal opcode
        p = '{8'hA9, 8'h7F, 8'hFF};
        load_prog(p, 3);
        run_and_check_r2();
        chk("R10 illegal set", illegal, 1'b1);
        chk("R10 halted", halted, 1'b1);
        chk("R10 pc=3", pc, 16'd3);
        repeat (5) @(negedge clk);
        chk("R10 sticky", illegal, 1'b1);
        chk("R9 no reads while stopped", mem_rd, 1'b0);

        // restart mid-run
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
        for (int i = 0; i < 10; i++) begin
            prog[2*i]   = 8'hA9;
            prog[2*i+1] = 8'h11 * 8'(i + 1) ^ 8'h80;
        end
        pulse_start();
        repeat (7) @(posedge clk);
        #1 start = 1'b1;
        @(negedge clk);
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        chk("R11 refetch from 0", mem_addr, 16'h0000);
        chk("R11 read strobe", mem_rd, 1'b1);
        chk("R11 acc kept", acc, 8'h22 ^ 8'h80);
        wait_halt();
        chk("R11 final acc", acc, 8'hAA ^ 8'h80);
        chk("R9 pc=21", pc, 16'd21);

        // transfer of a negative value
        p = '{8'hAA, 8'h00};
        load_prog(p, 2);
        run_and_check_r2();
        chk("R5 xreg=2A", xreg, 8'h2A);
        chk("R7 negative from x", status, 8'h00);

        p = '{8'hA9, 8'hC3, 8'hAA, 8'h00};
        load_prog(p, 4);
        run_and_check_r2();
        chk("R7 negative from x", status, 8'h80);
        chk("R5 xreg=C3", xreg, 8'hC3);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule